// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block estimates the frequency of one clock picked from a bank of up to 128 candidate clocks. Software writes a single 32-bit control word holding a source index, a window length, a run bit and an enable bit. The block then counts rising edges of the chosen clock over a window timed by a divided-down reference tick, and captures the total into a result register. With the default divider the tick lands once per microsecond on a 50 MHz reference, so a programmed length of N−1 gives an N µs window and the frequency is count × 10⁶ / N.

Opening the input gate and starting the measurement are separate steps. Setting run opens the gate on the selected clock. The gated path must then see a fixed number of rising edges of that clock before any edge may be counted. Setting enable asks for a measurement. If the gate has already settled, counting starts at once. Otherwise the block waits, showing busy, until settling is complete. The selected clock is brought into the reference domain through a two-flop synchroniser, and only rising edges are counted. A result is therefore within one edge of the true value, and the measured clock must run below half the reference rate.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset the control word reads all zeros and the captured count reads zero.
- R2: The control word reads back as follows: window length minus one in bits 15:0, run in bit 16, enable in bit 17, source index in bits 26:20 and busy in bit 31. A write that sets both run and enable makes busy read high within two cycles.
- R3: A programmed length D gives a counting window of (D+1)·TICK_DIV reference cycles. When the gate has already settled, busy stays high for exactly that many cycles plus one.
- R4: A write that sets enable while clearing run is ignored. Enable reads 0, busy stays low and the captured count does not change.
- R5: No edge is counted until SETTLE_CYC rising edges of the gated clock have been seen since run was set. Selecting a different source, or clearing run, starts the settling over.
- R6: The captured count is the number of rising edges seen during the window. It lies within one of window/period for any clock below half the reference rate, and each rising edge yields exactly one count pulse.
- R7: Busy falls in the cycle after the last window cycle, and the enable bit clears itself at that point. The captured count stays constant until the next completed measurement.
- R8: If the window holds more edges than the count can represent, the count stops at all ones instead of wrapping.
- R9: Clearing enable or run while busy aborts the measurement. Busy drops and the previously captured count stays unchanged.
- R10: The source index selects srcClks[index] as the measured clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is clocked by it |
| rstN | input | 1 | Asynchronous active-low reset |
| srcClks | input | NUM_SRC | Candidate clocks to be measured |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlWdata | input | 32 | Control word write data |
| ctrlRdata | output | 32 | Control word read data, including busy |
| countOut | output | CNT_W | Last captured edge count |

## Verification
The bench builds the meter with four sources, a 6-bit count, an 8-bit length field and a tick every four reference cycles. The 24-edge settling stays at its real value. The narrow count lets a window of 320 cycles overflow it, so saturation is reached within a short run. The short tick also makes settle-wait and window lengths small enough to measure exactly in cycles. The four bench clocks have periods of 4, 6, 10 and 14 reference cycles, which makes it possible to check source selection, the ±1 edge bound, settling restarts when the source changes, and aborts through either control bit in mid-window.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;

  // Control word layout
  localparam int FLD_DUR_LSB = 0;
  localparam int FLD_DUR_W   = 16;
  localparam int FLD_RUN     = 16;
  localparam int FLD_EN      = 17;
  localparam int FLD_SEL_LSB = 20;
  localparam int FLD_SEL_W   = 7;
  localparam int FLD_BUSY    = 31;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_SETTLE = 2'd1,
    MS_COUNT  = 2'd2
  } measState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateOn;     // input gate open
    logic settleClr;  // restart settling
    logic startWin;   // first window cycle follows
    logic countEn;    // window open
    logic capture;    // last window cycle: latch the total
  } measStrobe_t;

endpackage

// File: rtl/clkmeas_sync.sv
module clkmeas_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= 1'b0;
        else       chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= 1'b0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkmeas_window.sv
module clkmeas_window #(
  parameter int TICK_DIV = 50,
  parameter int DUR_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             active,
  input  logic [DUR_W-1:0] durLast,
  output logic             lastCycle
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [DUR_W-1:0] tickCnt;
  logic             tick;

  assign tick = (preCnt == PRE_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (restart) preCnt <= '0;
    else if (tick)    preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tickCnt <= '0;
    else if (restart)         tickCnt <= '0;
    else if (active && tick)  tickCnt <= tickCnt + 1'b1;
  end

  assign lastCycle = active && tick && (tickCnt == durLast);
endmodule

// File: rtl/clkmeas_ctrl.sv
module clkmeas_ctrl
  import clkmeas_pkg::*;
#(
  parameter int SEL_W    = 7,
  parameter int DUR_W    = 16,
  parameter int TICK_DIV = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [31:0]      ctrlWdata,
  input  logic             settled,
  output measStrobe_t      strobes,
  output logic [SEL_W-1:0] selIdx,
  output logic             busy,
  output logic [31:0]      ctrlRdata
);
  logic [SEL_W-1:0] selReg;
  logic [DUR_W-1:0] durReg;
  logic             runReg;
  logic             enReg;
  measState_t       state, stateNext;
  logic             lastCycle;
  logic             abortReq;
  logic [SEL_W-1:0] wSel;
  logic [DUR_W-1:0] wDur;
  logic             wRun;
  logic             wEn;
  logic             unusedWdata;

  assign wSel        = ctrlWdata[FLD_SEL_LSB +: SEL_W];
  assign wDur        = ctrlWdata[FLD_DUR_LSB +: DUR_W];
  assign wRun        = ctrlWdata[FLD_RUN];
  assign wEn         = ctrlWdata[FLD_EN];
  assign unusedWdata = ^ctrlWdata;

  // Field registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      durReg <= '0;
      runReg <= 1'b0;
      enReg  <= 1'b0;
    end else if (ctrlWe) begin
      selReg <= wSel;
      durReg <= wDur;
      runReg <= wRun;
      enReg  <= wEn & wRun;
    end else if (strobes.capture) begin
      enReg  <= 1'b0;
    end
  end

  // Sequencing
  assign abortReq = !(enReg && runReg);

  always_comb begin
    stateNext         = state;
    strobes           = '0;
    strobes.gateOn    = runReg;
    strobes.countEn   = (state == MS_COUNT);
    strobes.settleClr = !runReg ||
                        (ctrlWe && ((wSel != selReg) || !wRun));
    unique case (state)
      MS_IDLE: begin
        if (enReg && runReg) stateNext = MS_SETTLE;
      end
      MS_SETTLE: begin
        if (abortReq) begin
          stateNext = MS_IDLE;
        end else if (settled) begin
          stateNext        = MS_COUNT;
          strobes.startWin = 1'b1;
        end
      end
      MS_COUNT: begin
        if (abortReq) begin
          stateNext = MS_IDLE;
        end else if (lastCycle) begin
          stateNext       = MS_IDLE;
          strobes.capture = 1'b1;
        end
      end
      default: stateNext = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MS_IDLE;
    else       state <= stateNext;
  end

  clkmeas_window #(
    .TICK_DIV (TICK_DIV),
    .DUR_W    (DUR_W)
  ) uWindow (
    .clk       (clk),
    .rstN      (rstN),
    .restart   (strobes.startWin),
    .active    (strobes.countEn),
    .durLast   (durReg),
    .lastCycle (lastCycle)
  );

  assign busy   = (state != MS_IDLE);
  assign selIdx = selReg;

  always_comb begin
    ctrlRdata                                = '0;
    ctrlRdata[FLD_DUR_LSB +: FLD_DUR_W]      = FLD_DUR_W'(durReg);
    ctrlRdata[FLD_RUN]                       = runReg;
    ctrlRdata[FLD_EN]                        = enReg;
    ctrlRdata[FLD_SEL_LSB +: FLD_SEL_W]      = FLD_SEL_W'(selReg);
    ctrlRdata[FLD_BUSY]                      = busy;
  end
endmodule

// File: rtl/clkmeas_dp.sv
module clkmeas_dp
  import clkmeas_pkg::*;
#(
  parameter int NUM_SRC     = 128,
  parameter int SEL_W       = 7,
  parameter int CNT_W       = 20,
  parameter int SETTLE_CYC  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClks,
  input  logic [SEL_W-1:0]   selIdx,
  input  measStrobe_t        strobes,
  output logic               settled,
  output logic               edgePulse,
  output logic [CNT_W-1:0]   countOut
);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ST_W-1:0]  ST_DONE = ST_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gatedClk;
  logic             syncOut;
  logic             edgeQ;
  logic [ST_W-1:0]  settleCnt;
  logic [CNT_W-1:0] accCnt;
  logic [CNT_W-1:0] accNext;
  logic [CNT_W-1:0] countReg;

  // Source mux and gate
  assign gatedClk = srcClks[selIdx] & strobes.gateOn;

  clkmeas_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (gatedClk),
    .dout (syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeQ <= 1'b0;
    else       edgeQ <= syncOut;
  end

  assign edgePulse = syncOut & ~edgeQ;

  // Settling: count edges seen through the open gate
  assign settled = (settleCnt == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      settleCnt <= '0;
    else if (strobes.settleClr)     settleCnt <= '0;
    else if (edgePulse && !settled) settleCnt <= settleCnt + 1'b1;
  end

  // Saturating edge accumulator
  assign accNext = (accCnt == CNT_MAX) ? accCnt : accCnt + CNT_W'(edgePulse);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 accCnt <= '0;
    else if (strobes.startWin) accCnt <= '0;
    else if (strobes.countEn)  accCnt <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countReg <= '0;
    else if (strobes.capture) countReg <= accNext;
  end

  assign countOut = countReg;
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import clkmeas_pkg::*;
#(
  parameter int NUM_SRC    = 128,
  parameter int CNT_W      = 20,
  parameter int DUR_W      = 16,
  parameter int SETTLE_CYC = 24,
  parameter int TICK_DIV   = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClks,
  input  logic               ctrlWe,
  input  logic [31:0]        ctrlWdata,
  output logic [31:0]        ctrlRdata,
  output logic [CNT_W-1:0]   countOut
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  measStrobe_t      strobes;
  logic [SEL_W-1:0] selIdx;
  logic             settled;
  logic             edgePulse;
  logic             busy;

  clkmeas_ctrl #(
    .SEL_W    (SEL_W),
    .DUR_W    (DUR_W),
    .TICK_DIV (TICK_DIV)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .settled   (settled),
    .strobes   (strobes),
    .selIdx    (selIdx),
    .busy      (busy),
    .ctrlRdata (ctrlRdata)
  );

  clkmeas_dp #(
    .NUM_SRC    (NUM_SRC),
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .srcClks   (srcClks),
    .selIdx    (selIdx),
    .strobes   (strobes),
    .settled   (settled),
    .edgePulse (edgePulse),
    .countOut  (countOut)
  );
endmodule

// File: rtl/clkmeas_chk.sv
module clkmeas_chk
  import clkmeas_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWe,
  input logic [31:0]      ctrlWdata,
  input logic             busy,
  input logic             settled,
  input logic             edgePulse,
  input measStrobe_t      strobes,
  input logic [CNT_W-1:0] countOut
);
  // R7: result only moves on a capture
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(countOut));

  // R7: busy low right after the last window cycle
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !busy);

  // R5: settling completes only on a counted edge
  p_settle_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settled) |-> $past(edgePulse));

  // R6: one pulse per rising edge, never two in a row
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);

  // R9: clearing enable mid-run drops busy and keeps the result
  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWe && !ctrlWdata[FLD_EN] && !strobes.capture)
      |=> ##1 (!busy && $stable(countOut)));

  // R4: enable without run never leaves busy standing
  p_en_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlWe && ctrlWdata[FLD_EN] && !ctrlWdata[FLD_RUN])
      |=> ##1 !busy);
endmodule

bind clk_freq_meter clkmeas_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlWe    (ctrlWe),
  .ctrlWdata (ctrlWdata),
  .busy      (busy),
  .settled   (settled),
  .edgePulse (edgePulse),
  .strobes   (strobes),
  .countOut  (countOut)
);

// File: tb/tb_clk_freq_meter.sv
module tb_clk_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC   = 4;
  localparam int CW     = 6;
  localparam int DW     = 8;
  localparam int SETTLE = 24;
  localparam int TDIV   = 4;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NSRC-1:0] srcClks = '0;
  logic          ctrlWe = 1'b0;
  logic [31:0]   ctrlWdata = '0;
  logic [31:0]   ctrlRdata;
  logic [CW-1:0] countOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  clk_freq_meter #(
    .NUM_SRC(NSRC), .CNT_W(CW), .DUR_W(DW),
    .SETTLE_CYC(SETTLE), .TICK_DIV(TDIV)
  ) dut (
    .clk(clk), .rstN(rstN), .srcClks(srcClks),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .countOut(countOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source clocks: periods 4, 6, 10, 14 reference cycles, edges off the clk edge
  initial begin #2; forever #20 srcClks[0] = ~srcClks[0]; end
  initial begin #2; forever #30 srcClks[1] = ~srcClks[1]; end
  initial begin #2; forever #50 srcClks[2] = ~srcClks[2]; end
  initial begin #2; forever #70 srcClks[3] = ~srcClks[3]; end

  // ---------------- behavioural reference model ----------------
  int m_sel, m_dur, m_run, m_en;
  int s1, s2, s3, m_settle, m_state, m_pre, m_tk, m_acc, m_cnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m_sel = 0; m_dur = 0; m_run = 0; m_en = 0;
      s1 = 0; s2 = 0; s3 = 0; m_settle = 0; m_state = 0;
      m_pre = 0; m_tk = 0; m_acc = 0; m_cnt = 0;
    end else begin
      int g, rise, sett, tick, last, clr, start, cap, ns, satv, wsel, wrun, wen;
      g     = srcClks[m_sel] & m_run;
      rise  = s2 & ~s3;
      sett  = (m_settle == SETTLE);
      tick  = (m_pre == TDIV - 1);
      last  = (m_state == 2) && tick && (m_tk == m_dur);
      wsel  = (ctrlWdata >> 20) & (NSRC - 1);
      wrun  = ctrlWdata[16];
      wen   = ctrlWdata[17];
      clr   = !m_run || (ctrlWe && ((wsel != m_sel) || !wrun));
      satv  = (m_acc == CMAX) ? m_acc : m_acc + rise;
      start = 0; cap = 0; ns = m_state;
      case (m_state)
        0: if (m_en && m_run) ns = 1;
        1: if (!(m_en && m_run)) ns = 0; else if (sett) begin ns = 2; start = 1; end
        default: if (!(m_en && m_run)) ns = 0; else if (last) begin ns = 0; cap = 1; end
      endcase
      m_settle = clr ? 0 : ((rise && !sett) ? m_settle + 1 : m_settle);
      if (cap) m_cnt = satv;
      m_acc = start ? 0 : ((m_state == 2) ? satv : m_acc);
      m_tk  = start ? 0 : ((m_state == 2 && tick) ? m_tk + 1 : m_tk);
      m_pre = start ? 0 : (tick ? 0 : m_pre + 1);
      if (ctrlWe) begin
        m_sel = wsel; m_dur = ctrlWdata & ((1 << DW) - 1);
        m_run = wrun; m_en = wen & wrun;
      end else if (cap) m_en = 0;
      s3 = s2; s2 = s1; s1 = g;
      m_state = ns;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int expRd;
      expRd = ((m_state != 0) << 31) | (m_sel << 20) | (m_en << 17) |
              (m_run << 16) | m_dur;
      total++;
      if (ctrlRdata !== 32'(expRd)) begin
        bad++;
        $display("FAIL R2 model control word act=%h exp=%h", ctrlRdata, expRd);
      end
      total++;
      if (countOut !== CW'(m_cnt)) begin
        bad++;
        $display("FAIL R6 model count act=%0d exp=%0d", countOut, m_cnt);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int sel, input int dur, input bit run, input bit en);
    return (32'(sel) << 20) | (32'(en) << 17) | (32'(run) << 16) | 32'(dur);
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWdata = w;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  // Start a measurement; return cycles until busy rose and cycles busy stayed high
  task automatic measure(input int sel, input int dur, output int riseDly, output int busyCyc);
    wr(word(sel, dur, 1'b1, 1'b1));
    riseDly = 0; busyCyc = 0;
    for (int i = 0; i < 5 && !ctrlRdata[31]; i++) begin
      @(negedge clk); riseDly++;
    end
    for (int i = 0; i < 20000 && ctrlRdata[31]; i++) begin
      busyCyc++; @(negedge clk);
    end
  endtask

  function automatic bit nearEdges(input int cnt, input int dur, input int per);
    int w;
    w = (dur + 1) * TDIV;
    return (cnt * per - w <= per) && (w - cnt * per <= per);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int dly, bc, c0, c2, prev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdata == 32'h0, "R1 control word after reset", ctrlRdata, 0);
    check(countOut == '0, "R1 count after reset", countOut, 0);

    // R4: enable without run
    wr(word(1, 9, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    check(ctrlRdata[17] == 1'b0, "R4 enable bit ignored", ctrlRdata[17], 0);
    check(ctrlRdata[31] == 1'b0, "R4 busy stays low", ctrlRdata[31], 0);
    check(countOut == '0, "R4 count untouched", countOut, 0);
    check(ctrlRdata[26:20] == 7'd1 && ctrlRdata[15:0] == 16'd9,
          "R2 field readback", ctrlRdata, word(1, 9, 0, 0));

    // R5/R2/R6: fresh source, settle then measure src2 (period 10)
    measure(2, 9, dly, bc);
    check(dly <= 2, "R2 busy rises after enable", dly, 1);
    check(bc >= (SETTLE - 1) * 10 + 40, "R5 settle wait before counting", bc, SETTLE * 10 + 40);
    check(nearEdges(countOut, 9, 10), "R6 src2 count within one edge", countOut, 4);
    check(ctrlRdata[17] == 1'b0, "R7 enable self-clears", ctrlRdata[17], 0);
    c2 = countOut;

    // R3: already settled, busy exactly window+1
    measure(2, 9, dly, bc);
    check(bc == (9 + 1) * TDIV + 1, "R3 busy length when settled", bc, 41);
    measure(2, 19, dly, bc);
    check(bc == (19 + 1) * TDIV + 1, "R3 busy length for longer window", bc, 81);
    check(nearEdges(countOut, 19, 10), "R3 count scales with window", countOut, 8);

    // R10/R5: other sources
    measure(0, 9, dly, bc);
    check(bc >= (SETTLE - 1) * 4 + 40, "R5 reselect restarts settling", bc, SETTLE * 4 + 40);
    check(nearEdges(countOut, 9, 4), "R10 src0 count", countOut, 10);
    c0 = countOut;
    check(c0 != c2, "R10 different sources differ", c0, c2 + 6);
    measure(1, 14, dly, bc);
    check(nearEdges(countOut, 14, 6), "R10 src1 count", countOut, 10);
    measure(3, 20, dly, bc);
    check(nearEdges(countOut, 20, 14), "R10 src3 count", countOut, 6);

    // R7: hold while idle
    prev = countOut;
    repeat (50) @(negedge clk);
    check(countOut == CW'(prev), "R7 count held while idle", countOut, prev);
    check(ctrlRdata[31] == 1'b0, "R7 busy low while idle", ctrlRdata[31], 0);

    // R9: abort by clearing enable
    wr(word(3, 100, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    check(ctrlRdata[31] == 1'b1, "R9 busy during long window", ctrlRdata[31], 1);
    wr(word(3, 100, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    check(ctrlRdata[31] == 1'b0, "R9 abort via enable clears busy", ctrlRdata[31], 0);
    check(countOut == CW'(prev), "R9 abort keeps count", countOut, prev);

    // R9: abort by clearing run
    wr(word(3, 100, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    wr(word(3, 100, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    check(ctrlRdata[31] == 1'b0, "R9 abort via run clears busy", ctrlRdata[31], 0);
    check(countOut == CW'(prev), "R9 run abort keeps count", countOut, prev);

    // R8: saturation, 80 edges into a 6-bit count
    measure(0, 79, dly, bc);
    check(countOut == CW'(CMAX), "R8 saturates at all ones", countOut, CMAX);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule